// File: doc/BRIEF.md
# Vector Upper-Half State Tracker

This block tracks whether the upper halves of a vector register file are live. The file has 16 entries of 256 bits. A stream of classified instruction events arrives, one per accepted cycle. Each event is one of five kinds:

- a legacy-encoded 128-bit operation,
- a new-encoded 128-bit operation,
- a new-encoded 256-bit operation,
- an upper-half clear,
- a full-register clear.

A three-state machine decides what each event costs:

- **Clean (A):** the upper halves are known empty.
- **Wide (B):** all 256 bits of every register are in use.
- **Split (C):** the upper halves are parked in an internal save buffer, and legacy code works on the lower halves.

Moving from Wide to Split copies the upper halves into the buffer. Moving from Split back to Wide copies them back. Both moves raise a stall for a fixed number of cycles. The two dedicated clear events return the machine to Clean at no cost, except when it starts from Split.

A read and write port on the register file lets the surrounding logic, or a bench, load values and observe what was saved, cleared and restored. Instruction decode, the execution units and the lower-half datapath are not part of this block.

Top module: `vup_tracker`

## Requirements
- R1: After synchronous reset, `mode_state` is 0 (Clean), `stall` is 0, `ev_ready` is 1 and every register reads all zeros.
- R2: States are encoded as Clean=0, Wide=1 and Split=2. Event kinds on `ev_kind` are: 0 legacy 128-bit, 1 new-encoded 128-bit, 2 new-encoded 256-bit, 3 upper clear, 4 full clear. In Clean, kind 2 moves to Wide without a stall, and kinds 0 and 1 leave the state and the registers unchanged.
- R3: A kind 0 event in Wide moves to Split with a stall. At the end of the stall, bits 255:128 of all 16 registers are copied into the save buffer, even when they are zero, and then read as zero in the register file.
- R4: A penalty stall keeps `stall` high for exactly `STALL_CYCLES` consecutive cycles. The default is 70 and the legal range is 50 to 80. `ev_ready` is low exactly while `stall` is high.
- R5: A kind 2 event in Split moves to Wide with a stall. At the end of the stall, bits 255:128 of every register are reloaded from the save buffer, and bits 127:0 keep their current values.
- R6: A kind 3 event in Clean or Wide moves to Clean with no stall. It zeroes bits 255:128 of all registers and keeps bits 127:0.
- R7: A kind 4 event in Clean or Wide moves to Clean with no stall and zeroes every register entirely.
- R8: A kind 3 or kind 4 event in Split moves to Clean with a stall. At the end of the stall it clears the registers as in R6 or R7 respectively.
- R9: Writing zeros into the upper halves through the write port does not change the state. A later kind 0 event in Wide is still charged the full stall.
- R10: Kinds 0 and 1 in Split, kinds 1 and 2 in Wide, and the unused kinds 5 to 7 in any state cause no stall, no state change and no register change.
- R11: Events offered while `stall` is high are ignored. The state and the registers change only on the edge where the stall ends.
- R12: With `wr_en` high, `wr_data` is written in full to entry `wr_idx` on the next edge. `rd_data` shows entry `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An instruction event is offered |
| ev_kind | input | 3 | Event classification (R2 encoding) |
| ev_ready | output | 1 | High when an offered event is accepted |
| stall | output | 1 | Penalty stall in progress |
| mode_state | output | 2 | Current tracker state (0 Clean, 1 Wide, 2 Split) |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 256 | Register write data |
| rd_idx | input | 4 | Register read index |
| rd_data | output | 256 | Register read data |

## Verification
Penalty-free events take effect on the edge that accepts them, so the bench samples state and registers at the next falling edge. For a penalty event, `stall` is already high at that falling edge and the state is still the old one. The bench then counts falling edges while `stall` stays high, expects exactly `STALL_CYCLES` of them, and checks the new state and every register at the first falling edge where `stall` is low. Register writes are visible one edge after `wr_en`, and reads are combinational, so each readback is taken a fraction of a nanosecond after setting `rd_idx`, away from any clock edge.

// File: rtl/vup_pkg.sv
`timescale 1ns/1ps
package vup_pkg;

    localparam int NUM_REGS = 16;
    localparam int VLEN     = 256;
    localparam int HALF     = VLEN / 2;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int KIND_W   = 3;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_WIDE  = 2'd1,
        ST_SPLIT = 2'd2
    } vstate_e;

    localparam logic [KIND_W-1:0] KIND_LEG128 = 3'd0;
    localparam logic [KIND_W-1:0] KIND_VEX128 = 3'd1;
    localparam logic [KIND_W-1:0] KIND_VEX256 = 3'd2;
    localparam logic [KIND_W-1:0] KIND_ZUPPER = 3'd3;
    localparam logic [KIND_W-1:0] KIND_ZALL   = 3'd4;

    // Bulk action applied to the whole register file in one edge.
    typedef struct packed {
        logic clr_upper;
        logic clr_all;
        logic save;
        logic restore;
    } bulk_op_t;

    typedef struct packed {
        vstate_e  nxt;
        logic     penalty;
        bulk_op_t op;
    } decision_t;

    // Transition rules: what an accepted event does in a given state.
    function automatic decision_t decide(vstate_e cur, logic [KIND_W-1:0] kind);
        decision_t d;
        d.nxt     = cur;
        d.penalty = 1'b0;
        d.op      = '0;
        case (kind)
            KIND_VEX256: begin
                if (cur == ST_CLEAN) begin
                    d.nxt = ST_WIDE;
                end else if (cur == ST_SPLIT) begin
                    d.nxt        = ST_WIDE;
                    d.penalty    = 1'b1;
                    d.op.restore = 1'b1;
                end
            end
            KIND_LEG128: begin
                if (cur == ST_WIDE) begin
                    d.nxt     = ST_SPLIT;
                    d.penalty = 1'b1;
                    d.op.save = 1'b1;
                end
            end
            KIND_ZUPPER: begin
                d.nxt          = ST_CLEAN;
                d.op.clr_upper = 1'b1;
                d.penalty      = (cur == ST_SPLIT);
            end
            KIND_ZALL: begin
                d.nxt        = ST_CLEAN;
                d.op.clr_all = 1'b1;
                d.penalty    = (cur == ST_SPLIT);
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/vup_state_ctl.sv
`timescale 1ns/1ps
module vup_state_ctl
    import vup_pkg::*;
#(
    parameter int STALL_CYCLES = 70
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [KIND_W-1:0] ev_kind,
    output vstate_e           state,
    output logic              stall,
    output bulk_op_t          op
);
    localparam int CNT_W = $clog2(STALL_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    vstate_e          pend_state;
    bulk_op_t         pend_op;
    decision_t        dec;
    logic             accept;
    logic             finish;

    assign dec    = decide(state, ev_kind);
    assign stall  = (cnt != '0);
    assign accept = ev_valid && !stall;
    assign finish = (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_CLEAN;
            cnt        <= '0;
            pend_state <= ST_CLEAN;
            pend_op    <= '0;
        end else begin
            if (finish) begin
                state <= pend_state;
            end else if (accept && !dec.penalty) begin
                state <= dec.nxt;
            end
            if (accept && dec.penalty) begin
                cnt        <= CNT_W'(STALL_CYCLES);
                pend_state <= dec.nxt;
                pend_op    <= dec.op;
            end else if (stall) begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    // Deferred actions fire on the last stall edge; free ones fire at acceptance.
    always_comb begin
        if (finish) begin
            op = pend_op;
        end else if (accept && !dec.penalty) begin
            op = dec.op;
        end else begin
            op = '0;
        end
    end

    // Checker: length of each stall run, counted independently of cnt.
    logic [CNT_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)        run_len <= '0;
        else if (stall) run_len <= run_len + CNT_W'(1);
        else            run_len <= '0;
    end

    assert_state_legal_R2: assert property (@(posedge clk) disable iff (rst)
        state != 2'd3);

    assert_stall_len_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> run_len == CNT_W'(STALL_CYCLES));

    assert_hold_in_stall_R11: assert property (@(posedge clk) disable iff (rst)
        stall |-> $stable(state));

    assert_leg_penalty_R3: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !stall && ev_kind == KIND_LEG128 && state == ST_WIDE)
        |=> (stall && state == ST_WIDE));

    assert_zero_free_R6: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !stall && ev_kind == KIND_ZUPPER && state != ST_SPLIT)
        |=> (state == ST_CLEAN && !stall));

    assert_widen_free_R2: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !stall && ev_kind == KIND_VEX256 && state == ST_CLEAN)
        |=> (state == ST_WIDE && !stall));

endmodule

// File: rtl/vup_save_buf.sv
`timescale 1ns/1ps
module vup_save_buf
    import vup_pkg::*;
#(
    parameter int N_REGS = NUM_REGS,
    parameter int H_BITS = HALF
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           save,
    input  logic [N_REGS-1:0][H_BITS-1:0]  upper_in,
    output logic [N_REGS-1:0][H_BITS-1:0]  buf_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_out <= '0;
        end else if (save) begin
            buf_out <= upper_in;
        end
    end

    assert_save_copy_R3: assert property (@(posedge clk) disable iff (rst)
        save |=> buf_out == $past(upper_in));

    assert_buf_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !save |=> $stable(buf_out));

endmodule

// File: rtl/vup_regfile.sv
`timescale 1ns/1ps
module vup_regfile
    import vup_pkg::*;
#(
    parameter int N_REGS = NUM_REGS,
    parameter int W      = VLEN
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  bulk_op_t                               op,
    input  logic                                   wr_en,
    input  logic [$clog2(N_REGS)-1:0]              wr_idx,
    input  logic [W-1:0]                           wr_data,
    input  logic [$clog2(N_REGS)-1:0]              rd_idx,
    output logic [W-1:0]                           rd_data,
    input  logic [N_REGS-1:0][W/2-1:0]             restore_in,
    output logic [N_REGS-1:0][W/2-1:0]             upper_out
);
    localparam int H  = W / 2;
    localparam int IW = $clog2(N_REGS);

    logic [W-1:0] rf_q [N_REGS];
    logic [W-1:0] rf_d [N_REGS];
    logic         any_set;

    always_comb begin
        for (int i = 0; i < N_REGS; i++) begin
            rf_d[i] = rf_q[i];
            if (wr_en && wr_idx == IW'(i)) begin
                rf_d[i] = wr_data;
            end
            if (op.clr_all) begin
                rf_d[i] = '0;
            end else if (op.clr_upper || op.save) begin
                rf_d[i][W-1:H] = '0;
            end else if (op.restore) begin
                rf_d[i][W-1:H] = restore_in[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_REGS; i++) rf_q[i] <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    for (genvar g = 0; g < N_REGS; g++) begin : g_upper
        assign upper_out[g] = rf_q[g][W-1:H];
    end

    assign rd_data = rf_q[rd_idx];

    always_comb begin
        any_set = 1'b0;
        for (int i = 0; i < N_REGS; i++) any_set = any_set | (|rf_q[i]);
    end

    assert_zup_clear_R6: assert property (@(posedge clk) disable iff (rst)
        op.clr_upper |=> upper_out == '0);

    assert_zall_clear_R7: assert property (@(posedge clk) disable iff (rst)
        op.clr_all |=> !any_set);

    assert_restore_R5: assert property (@(posedge clk) disable iff (rst)
        op.restore |=> upper_out == $past(restore_in));

    assert_save_empties_R3: assert property (@(posedge clk) disable iff (rst)
        op.save |=> upper_out == '0);

endmodule

// File: rtl/vup_tracker.sv
`timescale 1ns/1ps
module vup_tracker
    import vup_pkg::*;
#(
    parameter int STALL_CYCLES = 70
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [2:0]        ev_kind,
    output logic              ev_ready,
    output logic              stall,
    output logic [1:0]        mode_state,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [255:0]      wr_data,
    input  logic [3:0]        rd_idx,
    output logic [255:0]      rd_data
);
    vstate_e                          state;
    bulk_op_t                         op;
    logic [NUM_REGS-1:0][HALF-1:0]    uppers;
    logic [NUM_REGS-1:0][HALF-1:0]    saved;

    vup_state_ctl #(.STALL_CYCLES(STALL_CYCLES)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .ev_kind  (ev_kind),
        .state    (state),
        .stall    (stall),
        .op       (op)
    );

    vup_regfile #(.N_REGS(NUM_REGS), .W(VLEN)) u_rf (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .restore_in (saved),
        .upper_out  (uppers)
    );

    vup_save_buf #(.N_REGS(NUM_REGS), .H_BITS(HALF)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .save     (op.save),
        .upper_in (uppers),
        .buf_out  (saved)
    );

    assign ev_ready   = !stall;
    assign mode_state = state;

    assert_ignore_in_stall_R11: assert property (@(posedge clk) disable iff (rst)
        (stall && $past(stall)) |-> $stable(mode_state));

endmodule

// File: tb/vup_tracker_tb.sv
`timescale 1ns/1ps
module vup_tracker_tb;
    localparam int P  = 70;
    localparam int NR = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ev_valid = 1'b0;
    logic [2:0]   ev_kind = '0;
    logic         ev_ready, stall;
    logic [1:0]   mode_state;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_idx = '0;
    logic [255:0] wr_data = '0;
    logic [3:0]   rd_idx = '0;
    logic [255:0] rd_data;

    always #4 clk = ~clk;

    vup_tracker #(.STALL_CYCLES(P)) u_dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_ready(ev_ready), .stall(stall), .mode_state(mode_state),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    int tests = 0;
    int fails = 0;
    logic [255:0] exp_rf  [NR];
    logic [127:0] exp_buf [NR];
    int exp_st;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [255:0] pat(input int seed, input int i);
        logic [255:0] v;
        for (int w = 0; w < 8; w++) v[w*32 +: 32] = 32'(seed*7919 + i*131 + w*17 + 1);
        if (seed % 3 == 0) v[255:128] = '0;
        return v;
    endfunction

    function automatic string req_of(input int st, input int k);
        if (k >= 5) return "R10";
        if (st == 0) return (k == 3) ? "R6" : (k == 4) ? "R7" : "R2";
        if (st == 1) return (k == 0) ? "R3" : (k == 3) ? "R6" : (k == 4) ? "R7" : "R10";
        return (k == 2) ? "R5" : (k >= 3) ? "R8" : "R10";
    endfunction

    // Expected effect of an accepted event, from the requirements.
    task automatic apply_model(input int k, output bit pen, output int ns);
        pen = 1'b0;
        ns  = exp_st;
        if (k == 4) begin
            for (int i = 0; i < NR; i++) exp_rf[i] = '0;
            ns = 0; pen = (exp_st == 2);
        end else if (k == 3) begin
            for (int i = 0; i < NR; i++) exp_rf[i][255:128] = '0;
            ns = 0; pen = (exp_st == 2);
        end else if (k == 0 && exp_st == 1) begin
            for (int i = 0; i < NR; i++) begin
                exp_buf[i] = exp_rf[i][255:128];
                exp_rf[i][255:128] = '0;
            end
            ns = 2; pen = 1'b1;
        end else if (k == 2 && exp_st == 2) begin
            for (int i = 0; i < NR; i++) exp_rf[i][255:128] = exp_buf[i];
            ns = 1; pen = 1'b1;
        end else if (k == 2 && exp_st == 0) begin
            ns = 1;
        end
    endtask

    task automatic check_regs(input string req);
        bit ok = 1'b1;
        logic [255:0] a = '0, e = '0;
        for (int i = 0; i < NR; i++) begin
            rd_idx = 4'(i);
            #0.05;
            if (rd_data !== exp_rf[i] && ok) begin
                ok = 1'b0; a = rd_data; e = exp_rf[i];
            end
        end
        chk(ok, req, "register contents", a, e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ev_valid = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NR; i++) begin exp_rf[i] = '0; exp_buf[i] = '0; end
        exp_st = 0;
    endtask

    task automatic wr_reg(input int i, input logic [255:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(i); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        exp_rf[i] = d;
    endtask

    task automatic run_event(input int k, input string extra);
        bit pen;
        int ns, old, n;
        string tag;
        old = exp_st;
        tag = req_of(old, k);
        apply_model(k, pen, ns);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = 3'(k);
        @(negedge clk);
        ev_valid = 1'b0;
        if (pen) begin
            chk(stall === 1'b1 && ev_ready === 1'b0, {"R4 ", tag, extra}, "stall/ready at start",
                {stall, ev_ready}, 2'b10);
            chk(mode_state == 2'(old), {"R11 ", tag}, "state held in stall", mode_state, old);
            n = 0;
            while (stall === 1'b1 && n < 1000) begin n++; @(negedge clk); end
            chk(n == P, {"R4 ", tag, extra}, "stall length", n, P);
        end else begin
            chk(stall === 1'b0 && ev_ready === 1'b1, {tag, extra}, "no stall", {stall, ev_ready}, 2'b01);
        end
        chk(mode_state == 2'(ns), {tag, extra}, "next state", mode_state, ns);
        check_regs({tag, extra});
        exp_st = ns;
    endtask

    initial begin
        logic [255:0] t;
        int n;
        bit rdy_seen;

        do_reset();
        chk(mode_state == 2'd0 && stall == 1'b0 && ev_ready == 1'b1, "R1", "reset outputs",
            {mode_state, stall, ev_ready}, 4'b0001);
        check_regs("R1");

        // R12: single write, readback of all entries
        wr_reg(5, pat(4, 5));
        check_regs("R12");
        wr_reg(15, pat(7, 15));
        check_regs("R12");

        // Sweep every start state against every event kind
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < 8; k++) begin
                int seed = s*8 + k + 1;
                do_reset();
                for (int i = 0; i < NR; i++) wr_reg(i, pat(seed, i));
                if (s >= 1) run_event(2, "");
                if (s == 2) begin
                    run_event(0, "");
                    for (int i = 0; i < NR; i++) begin
                        t = pat(seed + 40, i);
                        wr_reg(i, {exp_rf[i][255:128], t[127:0]});
                    end
                end
                run_event(k, "");
            end
        end

        // R9: zeros written to upper halves do not make the state clean
        do_reset();
        for (int i = 0; i < NR; i++) wr_reg(i, pat(11, i));
        run_event(2, "");
        for (int i = 0; i < NR; i++) begin
            t = exp_rf[i]; t[255:128] = '0;
            wr_reg(i, t);
        end
        chk(mode_state == 2'd1, "R9", "state after zero writes", mode_state, 1);
        run_event(0, " R9");

        // R11: events offered during a stall are ignored
        do_reset();
        for (int i = 0; i < NR; i++) wr_reg(i, pat(13, i));
        run_event(2, "");
        begin
            bit pen; int ns;
            apply_model(0, pen, ns);
            @(negedge clk);
            ev_valid = 1'b1; ev_kind = 3'd0;
            @(negedge clk);
            ev_kind = 3'd4;
            n = 0; rdy_seen = 1'b0;
            for (int c = 0; c < 20; c++) begin
                if (ev_ready) rdy_seen = 1'b1;
                if (stall) n++;
                @(negedge clk);
            end
            ev_valid = 1'b0;
            chk(!rdy_seen, "R11", "ready low during stall", rdy_seen, 0);
            while (stall === 1'b1 && n < 1000) begin n++; @(negedge clk); end
            chk(n == P, "R11 R4", "stall length with offered events", n, P);
            chk(mode_state == 2'(ns), "R11", "state ignores offered events", mode_state, ns);
            check_regs("R11");
            exp_st = ns;
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R4 watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule